// File: doc/BRIEF.md
# Frame-Synchronised Window Configuration Bank

This block keeps the per-window configuration of a display overlay engine in two copies. Software writes a pending copy of each window's frame buffer start and end address, line pitch and skip, screen rectangle and enable through a simple word-wide register bus. A shadow copy, which is the one the pixel pipeline sees, takes over the pending values only on a frame-sync pulse. This guarantees that the scan-out never sees a half-written window.

A shared control word carries a guard bit and a fetch-enable bit for each window. While a window's guard bit is set, the frame-sync pulse leaves that window's shadow copy untouched. Software can therefore rewrite several registers of one window over any number of frames, clear the guard, and have the whole set take effect together at the following pulse. The fetch-enable bit of a window is moved into the shadow copy together with the rest of that window's fields. From the shadow copy and the current pixel coordinate, the block flags, per window, whether the pixel falls inside that window.

Top module: `win_shadow_bank`

## Requirements
- R1: After a synchronous active-low reset, every pending and shadow field, every guard bit, every shadow output and every hit flag reads zero.
- R2: A bus write changes only the pending copy. The shadow outputs of every window stay unchanged in every cycle in which `vsync` is low.
- R3: On a clock edge with `vsync` high and a window's guard bit clear, that window's shadow fields take the pending values held just before that edge. They are visible on the outputs after that edge.
- R4: On a clock edge with `vsync` high and a window's guard bit set, that window's shadow fields keep their values.
- R5: After software clears a guard bit, the pending values of that window reach the shadow outputs at the next `vsync` edge. They do not reach them before that edge.
- R6: Reading a window register returns its pending value, even while the shadow copy differs. Window w occupies byte addresses 16*w to 16*w+12. Word 0 is the start address. Word 1 is the end address. Word 2 holds the line pitch in bits [14:0], the line skip in bits [29:15] and the window enable in bit 31. Word 3 holds the left x in [7:0], the top y in [15:8], the right x in [23:16] and the bottom y in [31:24]. Address bits [1:0] are ignored.
- R7: The control word at byte address 0x80 holds guard bit w in bit w and fetch-enable bit w in bit 8+w. A write takes effect at once and reads back the written bits. The guard itself is never shadowed.
- R8: `win_hit[w]` is high exactly when the shadow window enable and the shadow fetch enable of window w are both set, and left ≤ `px_x` ≤ right and top ≤ `px_y` ≤ bottom, with both edges inclusive.
- R9: A write to a byte address that is neither inside a window block nor equal to 0x80 changes no state, and a read of such an address returns zero.
- R10: A set guard bit on one window does not stop the shadow transfer of any other unguarded window at the same `vsync` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| vsync | input | 1 | Frame-sync pulse, one clock wide |
| px_x | input | 8 | Current pixel column |
| px_y | input | 8 | Current pixel row |
| win_hit | output | 5 | Per-window inside flag |
| sh_buf_start | output | 160 | Shadow start addresses, window w at [32w+31:32w] |
| sh_buf_end | output | 160 | Shadow end addresses |
| sh_pagew | output | 75 | Shadow line pitch, 15 bits per window |
| sh_offs | output | 75 | Shadow line skip, 15 bits per window |
| sh_win_en | output | 5 | Shadow window enable |
| sh_chan_en | output | 5 | Shadow fetch enable |

## Verification
The properties assume that `vsync` is a single-cycle pulse sampled on the same clock as the bus, and that a bus write and a frame pulse may share a cycle; in that case the shadow copy takes the value from before the write. The stimulus only changes inputs on the falling edge and uses word-aligned addresses. It keeps the guard bit of the window under test stable across each pulse, so each transfer or hold is decided by one known guard value. The coordinates used for the hit checks lie on, just inside and just outside each rectangle edge.

// File: rtl/wsb_pkg.sv
// Shared widths, field positions and the per-window configuration record
// for the frame-synchronised window configuration bank.
package wsb_pkg;
    parameter int WSB_NWIN   = 5;   // number of overlay windows
    parameter int WSB_AW     = 32;  // frame buffer address width
    parameter int WSB_PW     = 15;  // pitch / skip field width
    parameter int WSB_CW     = 8;   // screen coordinate width
    parameter int WSB_BUS_AW = 8;   // register bus byte address width
    parameter int WSB_DW     = 32;  // register bus data width

    localparam int WSB_STRIDE_B  = 16;                 // bytes per window block
    localparam int WSB_CTRL_ADDR = 8 * WSB_STRIDE_B;   // control word byte address
    localparam int WSB_SKIP_LSB  = WSB_PW;             // line skip position in word 2
    localparam int WSB_EN_BIT    = WSB_DW - 1;         // window enable position
    localparam int WSB_CHAN_LSB  = 8;                  // fetch enables in control word

    // word selector inside one window block
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_STOP  = 2'd1,
        SEL_GEOM  = 2'd2,
        SEL_RECT  = 2'd3
    } wsb_sel_e;

    typedef struct packed {
        logic [WSB_AW-1:0] start;
        logic [WSB_AW-1:0] stop;
        logic [WSB_PW-1:0] skip;
        logic [WSB_PW-1:0] pitch;
        logic              en;
        logic              chan;
        logic [WSB_CW-1:0] left;
        logic [WSB_CW-1:0] top;
        logic [WSB_CW-1:0] right;
        logic [WSB_CW-1:0] bottom;
    } wsb_cfg_t;
endpackage

// File: rtl/wsb_regfile.sv
// Pending register file: decodes the register bus, holds the software-visible
// copy of every window plus the immediate guard bits, and serves reads.
// Assumes word-aligned accesses; address bits [1:0] are ignored.
module wsb_regfile
    import wsb_pkg::*;
#(
    parameter int NWIN = WSB_NWIN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [WSB_BUS_AW-1:0] bus_addr,
    input  logic [WSB_DW-1:0]     bus_wdata,
    output logic [WSB_DW-1:0]     bus_rdata,
    output wsb_cfg_t [NWIN-1:0]   pend,
    output logic [NWIN-1:0]       guard
);
    localparam int WIN_SPAN = NWIN * WSB_STRIDE_B;

    logic [3:0] win_idx;
    wsb_sel_e   sel;
    logic       hit_win;
    logic       hit_ctrl;

    // Address decode shared by write and read paths.
    always_comb begin
        win_idx  = bus_addr[7:4];
        sel      = wsb_sel_e'(bus_addr[3:2]);
        hit_win  = (int'(bus_addr) < WIN_SPAN);
        hit_ctrl = (int'(bus_addr) == WSB_CTRL_ADDR);
    end

    genvar w;
    generate
        for (w = 0; w < NWIN; w++) begin : g_win
            // Pending window fields: written through the bus, fetch enable from the control word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend[w] <= '0;
                end else if (bus_wr && hit_win && (int'(win_idx) == w)) begin
                    case (sel)
                        SEL_START: pend[w].start <= bus_wdata[WSB_AW-1:0];
                        SEL_STOP:  pend[w].stop  <= bus_wdata[WSB_AW-1:0];
                        SEL_GEOM: begin
                            pend[w].pitch <= bus_wdata[WSB_PW-1:0];
                            pend[w].skip  <= bus_wdata[WSB_SKIP_LSB +: WSB_PW];
                            pend[w].en    <= bus_wdata[WSB_EN_BIT];
                        end
                        default: begin
                            pend[w].left   <= bus_wdata[0*WSB_CW +: WSB_CW];
                            pend[w].top    <= bus_wdata[1*WSB_CW +: WSB_CW];
                            pend[w].right  <= bus_wdata[2*WSB_CW +: WSB_CW];
                            pend[w].bottom <= bus_wdata[3*WSB_CW +: WSB_CW];
                        end
                    endcase
                end else if (bus_wr && hit_ctrl) begin
                    pend[w].chan <= bus_wdata[WSB_CHAN_LSB + w];
                end
            end
        end
    endgenerate

    // Guard bits act immediately and are never shadowed.
    always_ff @(posedge clk) begin
        if (!rst_n)                guard <= '0;
        else if (bus_wr && hit_ctrl) guard <= bus_wdata[NWIN-1:0];
    end

    // Read mux: always returns the pending copy.
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[NWIN-1:0] = guard;
            for (int i = 0; i < NWIN; i++) bus_rdata[WSB_CHAN_LSB + i] = pend[i].chan;
        end else if (hit_win) begin
            for (int i = 0; i < NWIN; i++) begin
                if (int'(win_idx) == i) begin
                    case (sel)
                        SEL_START: bus_rdata[WSB_AW-1:0] = pend[i].start;
                        SEL_STOP:  bus_rdata[WSB_AW-1:0] = pend[i].stop;
                        SEL_GEOM: begin
                            bus_rdata[WSB_PW-1:0]              = pend[i].pitch;
                            bus_rdata[WSB_SKIP_LSB +: WSB_PW]  = pend[i].skip;
                            bus_rdata[WSB_EN_BIT]              = pend[i].en;
                        end
                        default: bus_rdata = {pend[i].bottom, pend[i].right,
                                              pend[i].top, pend[i].left};
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/wsb_shadow.sv
// Shadow copy: each window loads its pending record on a frame-sync edge
// unless its guard bit is set. Assumes vsync is synchronous to clk.
module wsb_shadow
    import wsb_pkg::*;
#(
    parameter int NWIN = WSB_NWIN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vsync,
    input  logic [NWIN-1:0]     guard,
    input  wsb_cfg_t [NWIN-1:0] pend,
    output wsb_cfg_t [NWIN-1:0] shad
);
    genvar w;
    generate
        for (w = 0; w < NWIN; w++) begin : g_sh
            // Per-window frame-synchronised load, blocked by the guard.
            always_ff @(posedge clk) begin
                if (!rst_n)                  shad[w] <= '0;
                else if (vsync && !guard[w]) shad[w] <= pend[w];
            end
        end
    endgenerate
endmodule

// File: rtl/wsb_hit.sv
// Inside-window test per window on the shadow copy, inclusive edges,
// gated by the shadow window enable and fetch enable. Purely combinational.
module wsb_hit
    import wsb_pkg::*;
#(
    parameter int NWIN = WSB_NWIN
) (
    input  wsb_cfg_t [NWIN-1:0] shad,
    input  logic [WSB_CW-1:0]   px_x,
    input  logic [WSB_CW-1:0]   px_y,
    output logic [NWIN-1:0]     hit
);
    genvar w;
    generate
        for (w = 0; w < NWIN; w++) begin : g_hit
            // Rectangle compare for one window.
            always_comb begin
                hit[w] = shad[w].en && shad[w].chan
                      && (px_x >= shad[w].left) && (px_x <= shad[w].right)
                      && (px_y >= shad[w].top)  && (px_y <= shad[w].bottom);
            end
        end
    endgenerate
endmodule

// File: rtl/win_shadow_bank.sv
// Top of the window configuration bank: pending register file, frame-synced
// shadow copy and inside-window flags; shadow fields are flattened to ports.
module win_shadow_bank
    import wsb_pkg::*;
#(
    parameter int NWIN = WSB_NWIN
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [WSB_BUS_AW-1:0]  bus_addr,
    input  logic [WSB_DW-1:0]      bus_wdata,
    output logic [WSB_DW-1:0]      bus_rdata,
    input  logic                   vsync,
    input  logic [WSB_CW-1:0]      px_x,
    input  logic [WSB_CW-1:0]      px_y,
    output logic [NWIN-1:0]        win_hit,
    output logic [NWIN*WSB_AW-1:0] sh_buf_start,
    output logic [NWIN*WSB_AW-1:0] sh_buf_end,
    output logic [NWIN*WSB_PW-1:0] sh_pagew,
    output logic [NWIN*WSB_PW-1:0] sh_offs,
    output logic [NWIN-1:0]        sh_win_en,
    output logic [NWIN-1:0]        sh_chan_en
);
    wsb_cfg_t [NWIN-1:0] pend_w;
    wsb_cfg_t [NWIN-1:0] shad_w;
    logic [NWIN-1:0]     guard_w;

    wsb_regfile #(.NWIN(NWIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend_w), .guard(guard_w)
    );

    wsb_shadow #(.NWIN(NWIN)) u_shadow (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .guard(guard_w),
        .pend(pend_w), .shad(shad_w)
    );

    wsb_hit #(.NWIN(NWIN)) u_hit (
        .shad(shad_w), .px_x(px_x), .px_y(px_y), .hit(win_hit)
    );

    genvar w;
    generate
        for (w = 0; w < NWIN; w++) begin : g_out
            // Flatten one window's shadow record onto the output buses.
            assign sh_buf_start[w*WSB_AW +: WSB_AW] = shad_w[w].start;
            assign sh_buf_end[w*WSB_AW +: WSB_AW]   = shad_w[w].stop;
            assign sh_pagew[w*WSB_PW +: WSB_PW]     = shad_w[w].pitch;
            assign sh_offs[w*WSB_PW +: WSB_PW]      = shad_w[w].skip;
            assign sh_win_en[w]                     = shad_w[w].en;
            assign sh_chan_en[w]                    = shad_w[w].chan;
        end
    endgenerate
endmodule

// File: rtl/wsb_chk.sv
// Property checker for the window configuration bank, bound to the top.
// Assumes vsync and bus inputs are synchronous to clk.
module wsb_chk
    import wsb_pkg::*;
#(
    parameter int NWIN = WSB_NWIN
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vsync,
    input logic                  bus_wr,
    input logic [WSB_BUS_AW-1:0] bus_addr,
    input logic [NWIN-1:0]       guard,
    input wsb_cfg_t [NWIN-1:0]   pend,
    input wsb_cfg_t [NWIN-1:0]   shad,
    input logic [NWIN-1:0]       win_hit
);
    logic mapped;
    // Whether the current bus address selects any state.
    always_comb mapped = (int'(bus_addr) < NWIN * WSB_STRIDE_B)
                      || (int'(bus_addr) == WSB_CTRL_ADDR);

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(pend) && $stable(guard)));

    genvar w;
    generate
        for (w = 0; w < NWIN; w++) begin : g_w
            // R2
            quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !vsync |=> $stable(shad[w]));
            // R4
            guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (vsync && guard[w]) |=> $stable(shad[w]));
            // R3
            frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (vsync && !guard[w]) |=> (shad[w] == $past(pend[w])));
            // R8
            hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                win_hit[w] |-> (shad[w].en && shad[w].chan));
        end
    endgenerate
endmodule

bind win_shadow_bank wsb_chk #(.NWIN(NWIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .guard(guard_w), .pend(pend_w), .shad(shad_w), .win_hit(win_hit)
);

// File: tb/win_shadow_bank_bench.sv
module win_shadow_bank_bench;
    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vsync = 1'b0;
    logic [7:0]  px_x = '0, px_y = '0;
    logic [NW-1:0]    win_hit, sh_win_en, sh_chan_en;
    logic [NW*32-1:0] sh_buf_start, sh_buf_end;
    logic [NW*15-1:0] sh_pagew, sh_offs;

    win_shadow_bank u_win_shadow_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vsync(vsync),
        .px_x(px_x), .px_y(px_y), .win_hit(win_hit),
        .sh_buf_start(sh_buf_start), .sh_buf_end(sh_buf_end),
        .sh_pagew(sh_pagew), .sh_offs(sh_offs),
        .sh_win_en(sh_win_en), .sh_chan_en(sh_chan_en)
    );

    always #4 clk = ~clk;  // 125 MHz

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural model: raw register images, pending and shadow
    logic [31:0] p_word [NW][4];
    logic [31:0] s_word [NW][4];
    logic [NW-1:0] p_chan, s_chan, m_guard;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int w;
        if (a == 8'h80) return {16'h0, 3'b0, p_chan, 3'b0, m_guard};
        if (a < 8'h50) begin
            w = a / 16;
            return p_word[w][(a % 16) / 4];
        end
        return 32'h0;
    endfunction

    function automatic logic model_hit(input int w);
        logic [31:0] r;
        r = s_word[w][3];
        return s_word[w][2][31] && s_chan[w]
            && px_x >= r[7:0] && px_x <= r[23:16]
            && px_y >= r[15:8] && px_y <= r[31:24];
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Model update at the edge, then compare every output after it.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++)
                for (int k = 0; k < 4; k++) begin p_word[w][k] = 0; s_word[w][k] = 0; end
            p_chan = 0; s_chan = 0; m_guard = 0;
        end else begin
            for (int w = 0; w < NW; w++)
                if (vsync && !m_guard[w]) begin
                    for (int k = 0; k < 4; k++) s_word[w][k] = p_word[w][k];
                    s_chan[w] = p_chan[w];
                end
            if (bus_wr) begin
                if (bus_addr == 8'h80) begin
                    m_guard = bus_wdata[NW-1:0];
                    p_chan  = bus_wdata[8 +: NW];
                end else if (bus_addr < 8'h50) begin
                    p_word[bus_addr / 16][(bus_addr % 16) / 4] =
                        ((bus_addr % 16) / 4 == 2) ? (bus_wdata & 32'hBFFF_FFFF) : bus_wdata;
                end
            end
        end
        #2;
        if (!done) begin
            for (int w = 0; w < NW; w++) begin
                check({cur_req, " start"}, sh_buf_start[w*32 +: 32], s_word[w][0]);
                check({cur_req, " end"},   sh_buf_end[w*32 +: 32],   s_word[w][1]);
                check({cur_req, " pitch"}, {17'h0, sh_pagew[w*15 +: 15]}, {17'h0, s_word[w][2][14:0]});
                check({cur_req, " skip"},  {17'h0, sh_offs[w*15 +: 15]},  {17'h0, s_word[w][2][29:15]});
                check({cur_req, " en"},    {31'h0, sh_win_en[w]},  {31'h0, s_word[w][2][31]});
                check({cur_req, " chan"},  {31'h0, sh_chan_en[w]}, {31'h0, s_chan[w]});
                check({cur_req, " hit"},   {31'h0, win_hit[w]},    {31'h0, model_hit(w)});
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk); bus_addr = a; #1;
        check(req, bus_rdata, exp);
        check({req, " model"}, bus_rdata, model_read(a));
    endtask

    task automatic pix(input string req, input logic [7:0] x, input logic [7:0] y,
                       input logic [NW-1:0] exp);
        @(negedge clk); px_x = x; px_y = y; #1;
        check(req, {27'h0, win_hit}, {27'h0, exp});
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        rd("R1 ctrl", 8'h80, 32'h0);
        rd("R1 win1 start", 8'h10, 32'h0);
        pix("R1 hit", 8'd0, 8'd0, 5'b0);

        // R2 / R6: pending writes, shadow unchanged
        cur_req = "R2";
        wr(8'h10, 32'h1000_0000);
        wr(8'h14, 32'h1000_4000);
        wr(8'h18, {1'b1, 1'b0, 15'h0020, 15'h0140});
        wr(8'h1C, {8'd39, 8'd49, 8'd20, 8'd10});
        wr(8'h80, 32'h0000_0200);
        repeat (3) @(negedge clk);
        check("R2 start held", sh_buf_start[63:32], 32'h0);
        cur_req = "R6";
        rd("R6 start", 8'h10, 32'h1000_0000);
        rd("R6 rect", 8'h1C, 32'h2731_140A);
        rd("R7 ctrl", 8'h80, 32'h0000_0200);

        // R3: transfer on frame sync
        cur_req = "R3";
        frame();
        #1;
        check("R3 start", sh_buf_start[63:32], 32'h1000_0000);
        check("R3 pitch", {17'h0, sh_pagew[29:15]}, 32'h140);

        // R8: inclusive rectangle
        cur_req = "R8";
        pix("R8 top-left", 8'd10, 8'd20, 5'b00010);
        pix("R8 bottom-right", 8'd49, 8'd39, 5'b00010);
        pix("R8 right+1", 8'd50, 8'd39, 5'b00000);
        pix("R8 left-1", 8'd9, 8'd20, 5'b00000);
        pix("R8 bottom+1", 8'd30, 8'd40, 5'b00000);

        // R4 / R10: guard window 1, window 2 still loads
        cur_req = "R4";
        wr(8'h80, 32'h0000_0602);
        rd("R7 guard", 8'h80, 32'h0000_0602);
        wr(8'h10, 32'h2000_0000);
        wr(8'h20, 32'h3000_0000);
        wr(8'h28, {1'b1, 1'b0, 15'h0, 15'h0040});
        wr(8'h2C, {8'd50, 8'd60, 8'd30, 8'd40});
        rd("R6 pending while guarded", 8'h10, 32'h2000_0000);
        frame();
        #1;
        check("R4 guarded start", sh_buf_start[63:32], 32'h1000_0000);
        cur_req = "R10";
        check("R10 other window", sh_buf_start[95:64], 32'h3000_0000);
        pix("R10 overlap", 8'd45, 8'd35, 5'b00110);

        // R5: release guard, load waits for next frame
        cur_req = "R5";
        wr(8'h80, 32'h0000_0600);
        repeat (2) @(negedge clk);
        check("R5 before frame", sh_buf_start[63:32], 32'h1000_0000);
        frame();
        #1;
        check("R5 after frame", sh_buf_start[63:32], 32'h2000_0000);

        // R9: unmapped addresses
        cur_req = "R9";
        wr(8'h50, 32'hDEAD_BEEF);
        wr(8'h90, 32'hFFFF_FFFF);
        rd("R9 read 0x50", 8'h50, 32'h0);
        rd("R9 read 0x90", 8'h90, 32'h0);
        rd("R9 ctrl intact", 8'h80, 32'h0000_0600);
        rd("R9 win0 intact", 8'h00, 32'h0);
        rd("R9 win2 intact", 8'h20, 32'h3000_0000);

        // R8: fetch enable gates the hit
        cur_req = "R8";
        wr(8'h80, 32'h0000_0400);
        frame();
        pix("R8 fetch gate", 8'd45, 8'd35, 5'b00100);

        // R3: write and frame in the same cycle, shadow takes the old value
        cur_req = "R3";
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h4400_0000; vsync = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; vsync = 1'b0; #1;
        check("R3 same-cycle write", sh_buf_start[127:96], 32'h0);
        frame();
        #1;
        check("R3 next frame", sh_buf_start[127:96], 32'h4400_0000);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule